// File: doc/BRIEF.md
# Bitfield Extract, Insert and Swap Unit

This execution unit serves a 64-bit load/store core. It produces the result of one bit-manipulation operation per accepted request. It covers four kinds of work: pulling a contiguous field out of a source word, depositing a field into an old destination value, permuting bytes or halfwords, and sign-extending a byte or halfword. The request carries an operation code, the two raw 5-bit field bounds taken straight from the instruction word (`lsb`, `msb`), the source operand `rs` and the previous destination contents `rt`. Field position and size are derived inside the unit. The doubleword variants add a fixed offset of half the word width to the position or to the size.

Results leave through a single registered slot with a valid/ready handshake. An encoding whose bounds are inconsistent, or whose operation code is reserved, yields no result. It raises a one-cycle `illegal` pulse instead, which the core turns into a reserved-instruction trap. The word width is a parameter, a power of two of at least 32, and the default is 64.

Top module: `bitfield_unit`

## Requirements
- R1: Extract ops (op 0 word, op 1 double, op 2 double-with-upper-size, op 3 double-with-upper-position) return `rs` shifted right by the field position and masked to the field size. Op 0 and op 1 use position `lsb` and size `msb+1`. Op 2 uses position `lsb` and size `msb+33`. Op 3 uses position `lsb+32` and size `msb+1`. A size of 64 keeps every bit. Bits shifted in from beyond bit 63 are zero.
- R2: Insert ops (op 4 word, op 5 double, op 6 double-with-upper-size, op 7 double-with-upper-position) first form mask = ones(size) shifted left by the position. They return (`rt` & ~mask) | ((`rs` << position) & mask). Ops 4 and 5 use position `lsb` and size `msb-lsb+1`. Op 6 adds 32 to that size. Op 7 adds 32 to the position. Mask bits above bit 63 are dropped.
- R3: The word ops (op 0, op 4, op 8) replace bits 63..32 of their result with copies of bit 31.
- R4: Op 8 swaps the two bytes of each halfword in the low 32 bits of `rs`. Op 9 swaps the two bytes of every halfword across all 64 bits.
- R5: Op 10 returns `rs` with the order of its four halfwords reversed.
- R6: Op 11 returns bits 7..0 of `rs` sign-extended to 64 bits. Op 12 does the same for bits 15..0.
- R7: A request is illegal when any of these holds: op 0 has `lsb+msb` > 31; op 1, 2 or 3 has `lsb+msb` > 63; op 4, 5, 6 or 7 has `lsb` > `msb`; or op is 13, 14 or 15. For an accepted illegal request, `illegal` is high for exactly the following cycle, `out_valid` is low in that cycle, and no result is delivered.
- R8: `in_ready` is high whenever the output slot is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `result` and `out_valid` stay unchanged, and a presented request is not accepted. A cycle with `in_valid` low produces no result and no `illegal` pulse.
- R9: After reset, `out_valid` and `illegal` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high together with in_valid |
| op | input | 4 | Operation code (see R1 to R7) |
| lsb | input | 5 | Raw lower field bound from the instruction |
| msb | input | 5 | Raw upper field bound from the instruction |
| rs | input | 64 | Source operand |
| rt | input | 64 | Old destination value, used by insert ops |
| out_valid | output | 1 | Result slot holds a result |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 64 | Operation result |
| illegal | output | 1 | One-cycle pulse for an illegal request |

## Verification
The assertions rely on two things about the inputs. First, reset is applied before any request. Second, `op`, `lsb` and `msb` are known whenever `in_valid` is high. Under those conditions the decoded field size of a legal request always lies between one and the word width. The stimulus holds every request field at a defined value from reset onward. It walks all sixteen operation codes against every `lsb`/`msb` pair, and those are the only inputs the decode reads, so no out-of-range value can arise. Backpressure is exercised in a separate phase that holds `out_ready` low while a second request waits.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

   typedef enum logic [3:0] {
      BF_EXT   = 4'd0,
      BF_DEXT  = 4'd1,
      BF_DEXTM = 4'd2,
      BF_DEXTU = 4'd3,
      BF_INS   = 4'd4,
      BF_DINS  = 4'd5,
      BF_DINSM = 4'd6,
      BF_DINSU = 4'd7,
      BF_WSBH  = 4'd8,
      BF_DSBH  = 4'd9,
      BF_DSHD  = 4'd10,
      BF_SEB   = 4'd11,
      BF_SEH   = 4'd12
   } bf_op_e;

   typedef enum logic [2:0] {
      K_EXTRACT = 3'd0,
      K_INSERT  = 3'd1,
      K_BSWAP   = 3'd2,
      K_HREV    = 3'd3,
      K_SEXT8   = 3'd4,
      K_SEXT16  = 3'd5
   } bf_kind_e;

endpackage

// File: rtl/bf_decode.sv
module bf_decode
   import bfu_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int HALF = XLEN / 2,
   localparam int FW   = $clog2(HALF),
   localparam int PW   = $clog2(XLEN) + 1
) (
   input  logic [3:0]    op,
   input  logic [FW-1:0] lsb,
   input  logic [FW-1:0] msb,
   output bf_kind_e      kind,
   output logic [PW-1:0] pos,
   output logic [PW-1:0] size,
   output logic          narrow,
   output logic          illegal
);

   localparam logic [PW-1:0] HALF_P = PW'(HALF);
   localparam logic [PW-1:0] FULL_P = PW'(XLEN);

   logic [PW-1:0] lo, hi, sum, span;

   always_comb begin
      lo   = PW'(lsb);
      hi   = PW'(msb);
      sum  = lo + hi;
      span = hi - lo + PW'(1);
      kind    = K_EXTRACT;
      pos     = lo;
      size    = hi + PW'(1);
      narrow  = 1'b0;
      illegal = 1'b0;
      case (op)
         BF_EXT:   begin narrow = 1'b1; illegal = (sum > HALF_P - PW'(1)); end
         BF_DEXT:  illegal = (sum > FULL_P - PW'(1));
         BF_DEXTM: begin size = hi + PW'(1) + HALF_P; illegal = (sum > FULL_P - PW'(1)); end
         BF_DEXTU: begin pos = lo + HALF_P; illegal = (sum > FULL_P - PW'(1)); end
         BF_INS:   begin kind = K_INSERT; size = span; narrow = 1'b1; illegal = (lo > hi); end
         BF_DINS:  begin kind = K_INSERT; size = span; illegal = (lo > hi); end
         BF_DINSM: begin kind = K_INSERT; size = span + HALF_P; illegal = (lo > hi); end
         BF_DINSU: begin kind = K_INSERT; size = span; pos = lo + HALF_P; illegal = (lo > hi); end
         BF_WSBH:  begin kind = K_BSWAP; narrow = 1'b1; end
         BF_DSBH:  kind = K_BSWAP;
         BF_DSHD:  kind = K_HREV;
         BF_SEB:   kind = K_SEXT8;
         BF_SEH:   kind = K_SEXT16;
         default:  illegal = 1'b1;
      endcase
   end

   // R1/R2: a legal field always spans between one bit and the full word
   always_comb begin
      if (!illegal && !$isunknown(op) && (kind == K_EXTRACT || kind == K_INSERT))
         assert_size_range_R1: assert (size != '0 && size <= FULL_P);
   end

endmodule

// File: rtl/bf_field.sv
module bf_field #(
   parameter int XLEN = 64,
   localparam int PW = $clog2(XLEN) + 1
) (
   input  logic [XLEN-1:0] rs,
   input  logic [XLEN-1:0] rt,
   input  logic [PW-1:0]   pos,
   input  logic [PW-1:0]   size,
   input  logic            insert,
   output logic [XLEN-1:0] res
);

   localparam logic [PW-1:0] FULL_P = PW'(XLEN);

   logic [XLEN-1:0] ones, imask, ext_v, ins_v;

   always_comb begin
      ones  = {XLEN{1'b1}} >> (FULL_P - size);
      ext_v = (rs >> pos) & ones;
      imask = ones << pos;
      ins_v = (rt & ~imask) | ((rs << pos) & imask);
      res   = insert ? ins_v : ext_v;
   end

endmodule

// File: rtl/bf_permute.sv
module bf_permute #(
   parameter int XLEN = 64,
   parameter int MODE = 0
) (
   input  logic [XLEN-1:0] din,
   output logic [XLEN-1:0] dout
);

   generate
      if (MODE == 0) begin : g_pair_bytes
         for (genvar g = 0; g < XLEN / 8; g++) begin : g_b
            localparam int SRC = g ^ 1;
            assign dout[8*g +: 8] = din[8*SRC +: 8];
         end
      end else if (MODE == 1) begin : g_rev_halves
         localparam int NH = XLEN / 16;
         for (genvar g = 0; g < NH; g++) begin : g_h
            assign dout[16*g +: 16] = din[16*(NH-1-g) +: 16];
         end
      end else begin : g_bad_mode
         $error("bf_permute: MODE must be 0 or 1");
      end
   endgenerate

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
   import bfu_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int HALF = XLEN / 2,
   localparam int FW   = $clog2(HALF),
   localparam int PW   = $clog2(XLEN) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [3:0]      op,
   input  logic [FW-1:0]   lsb,
   input  logic [FW-1:0]   msb,
   input  logic [XLEN-1:0] rs,
   input  logic [XLEN-1:0] rt,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [XLEN-1:0] result,
   output logic            illegal
);

   generate
      if (XLEN < 32 || XLEN != 2 ** $clog2(XLEN)) begin : g_bad_xlen
         $error("bitfield_unit: XLEN must be a power of two of at least 32");
      end
   endgenerate

   bf_kind_e        kind;
   logic [PW-1:0]   pos, size;
   logic            narrow, dec_ill;
   logic [XLEN-1:0] field_res, bswap_res, hrev_res, raw, full;
   logic            vld_q, ill_q, accept;
   logic [XLEN-1:0] res_q;

   bf_decode #(.XLEN(XLEN)) u_dec (
      .op(op), .lsb(lsb), .msb(msb),
      .kind(kind), .pos(pos), .size(size), .narrow(narrow), .illegal(dec_ill)
   );

   bf_field #(.XLEN(XLEN)) u_field (
      .rs(rs), .rt(rt), .pos(pos), .size(size),
      .insert(kind == K_INSERT), .res(field_res)
   );

   bf_permute #(.XLEN(XLEN), .MODE(0)) u_bswap (.din(rs), .dout(bswap_res));
   bf_permute #(.XLEN(XLEN), .MODE(1)) u_hrev  (.din(rs), .dout(hrev_res));

   always_comb begin
      case (kind)
         K_BSWAP:  raw = bswap_res;
         K_HREV:   raw = hrev_res;
         K_SEXT8:  raw = {{(XLEN-8){rs[7]}}, rs[7:0]};
         K_SEXT16: raw = {{(XLEN-16){rs[15]}}, rs[15:0]};
         default:  raw = field_res;
      endcase
      full = narrow ? {{HALF{raw[HALF-1]}}, raw[HALF-1:0]} : raw;
   end

   assign in_ready = !vld_q || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         ill_q <= 1'b0;
         res_q <= '0;
      end else begin
         ill_q <= accept && dec_ill;
         if (accept) begin
            vld_q <= !dec_ill;
            if (!dec_ill) res_q <= full;
         end else if (out_ready) begin
            vld_q <= 1'b0;
         end
      end
   end

   assign out_valid = vld_q;
   assign result    = res_q;
   assign illegal   = ill_q;

   assert_no_result_on_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && illegal));

   assert_trap_from_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> $past(in_valid && in_ready));

   assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(result)));

   assert_legal_yields_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !dec_ill) |=> out_valid);

endmodule

// File: tb/test_bitfield_unit.sv
module test_bitfield_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [3:0]  op = '0;
   logic [4:0]  lsb = '0;
   logic [4:0]  msb = '0;
   logic [63:0] rs = '0;
   logic [63:0] rt = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [63:0] result;
   logic        illegal;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   bitfield_unit i_bitfield_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .op(op), .lsb(lsb), .msb(msb), .rs(rs), .rt(rt),
      .out_valid(out_valid), .out_ready(out_ready), .result(result), .illegal(illegal)
   );

   function automatic void model(input int o, input int lo, input int hi,
                                 input logic [63:0] a, input logic [63:0] b,
                                 output bit ill, output logic [63:0] r);
      int p, sz;
      bit ins, nar, fld;
      p = lo; sz = hi + 1; ins = 0; nar = 0; fld = 1; ill = 0; r = '0;
      case (o)
         0: begin nar = 1; ill = (lo + hi > 31); end
         1: ill = (lo + hi > 63);
         2: begin sz = hi + 33; ill = (lo + hi > 63); end
         3: begin p = lo + 32; ill = (lo + hi > 63); end
         4: begin ins = 1; nar = 1; sz = hi - lo + 1; ill = (lo > hi); end
         5: begin ins = 1; sz = hi - lo + 1; ill = (lo > hi); end
         6: begin ins = 1; sz = hi - lo + 33; ill = (lo > hi); end
         7: begin ins = 1; sz = hi - lo + 1; p = lo + 32; ill = (lo > hi); end
         8: begin fld = 0; nar = 1;
                  for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(k^1) +: 8]; end
         9: begin fld = 0;
                  for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(k^1) +: 8]; end
         10: begin fld = 0;
                  for (int k = 0; k < 4; k++) r[16*k +: 16] = a[16*(3-k) +: 16]; end
         11: begin fld = 0; r = {{56{a[7]}}, a[7:0]}; end
         12: begin fld = 0; r = {{48{a[15]}}, a[15:0]}; end
         default: begin fld = 0; ill = 1; end
      endcase
      if (fld && !ill) begin
         if (ins) r = b;
         for (int k = 0; k < sz; k++) begin
            if (p + k < 64) begin
               if (ins) r[p+k] = a[k];
               else     r[k]   = a[p+k];
            end
         end
      end
      if (nar) r = {{32{r[31]}}, r[31:0]};
   endfunction

   // drive one request at a negedge, let it be taken, return at the next negedge
   task automatic send(input int o, input int lo, input int hi,
                       input logic [63:0] a, input logic [63:0] b);
      op = 4'(o); lsb = 5'(lo); msb = 5'(hi); rs = a; rt = b; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_out(input string tag, input bit exp_ill, input logic [63:0] exp_r);
      checks++;
      if (exp_ill) begin
         if (out_valid !== 1'b0 || illegal !== 1'b1) begin
            errors++;
            $display("FAIL %s: valid=%b illegal=%b expected valid=0 illegal=1",
                     tag, out_valid, illegal);
         end
      end else if (out_valid !== 1'b1 || illegal !== 1'b0 || result !== exp_r) begin
         errors++;
         $display("FAIL %s: valid=%b illegal=%b result=%h expected valid=1 illegal=0 result=%h",
                  tag, out_valid, illegal, result, exp_r);
      end
   endtask

   task automatic expect_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      bit          e_ill;
      logic [63:0] e_r, a, b, first_r;
      string       tag;

      repeat (3) @(negedge clk);
      // R9: reset state
      expect_bit("R9 out_valid", out_valid, 1'b0);
      expect_bit("R9 illegal", illegal, 1'b0);
      expect_bit("R9 in_ready", in_ready, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: idle cycle gives nothing
      expect_bit("R8 idle valid", out_valid, 1'b0);
      expect_bit("R8 idle illegal", illegal, 1'b0);

      // full sweep: every op code against every lsb/msb pair, two operand pairs each
      for (int o = 0; o < 16; o++) begin
         for (int lo = 0; lo < 32; lo++) begin
            for (int hi = 0; hi < 32; hi++) begin
               for (int k = 0; k < 2; k++) begin
                  a = 64'((o * 4096 + lo * 64 + hi * 2 + k + 1)) * 64'h9E3779B97F4A7C15;
                  b = {a[31:0], a[63:32]} ^ 64'hA5A50F0F3C3CFF00;
                  model(o, lo, hi, a, b, e_ill, e_r);
                  if (e_ill)       tag = "R7";
                  else if (o < 4)  tag = "R1";
                  else if (o < 8)  tag = "R2";
                  else if (o < 10) tag = "R4";
                  else if (o == 10) tag = "R5";
                  else             tag = "R6";
                  send(o, lo, hi, a, b);
                  expect_out(tag, e_ill, e_r);
               end
            end
         end
      end

      // R3: directed sign-extension cases
      send(0, 0, 31, 64'h0000_0000_8000_0000, 64'h0);
      expect_out("R3 ext", 1'b0, 64'hFFFF_FFFF_8000_0000);
      send(4, 31, 31, 64'h1, 64'h0);
      expect_out("R3 ins", 1'b0, 64'hFFFF_FFFF_8000_0000);
      send(8, 0, 0, 64'h1234_5678_0080_0000, 64'h0);
      expect_out("R3 wsbh", 1'b0, 64'hFFFF_FFFF_8000_0000);
      // R5 and R6 literal cases
      send(10, 0, 0, 64'h1111_2222_3333_4444, 64'h0);
      expect_out("R5 hrev", 1'b0, 64'h4444_3333_2222_1111);
      send(11, 0, 0, 64'h0000_0000_0000_0080, 64'h0);
      expect_out("R6 seb", 1'b0, 64'hFFFF_FFFF_FFFF_FF80);
      // R1: full-width extract keeps every bit
      send(2, 0, 31, 64'hDEAD_BEEF_0123_4567, 64'h0);
      expect_out("R1 full", 1'b0, 64'hDEAD_BEEF_0123_4567);

      // R7: trap pulse lasts one cycle
      send(15, 0, 0, 64'h0, 64'h0);
      expect_out("R7 reserved", 1'b1, 64'h0);
      in_valid = 1'b0;
      @(negedge clk);
      expect_bit("R7 pulse end", illegal, 1'b0);
      expect_bit("R8 no result after trap", out_valid, 1'b0);

      // R8: backpressure
      out_ready = 1'b0;
      send(9, 0, 0, 64'h0102_0304_0506_0708, 64'h0);
      first_r = 64'h0201_0403_0605_0807;
      expect_out("R8 stall load", 1'b0, first_r);
      expect_bit("R8 in_ready low", in_ready, 1'b0);
      op = 4'd10; rs = 64'hAAAA_BBBB_CCCC_DDDD; in_valid = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         expect_out("R8 held", 1'b0, first_r);
      end
      out_ready = 1'b1;
      @(negedge clk);
      expect_out("R8 drained", 1'b0, 64'hDDDD_CCCC_BBBB_AAAA);
      in_valid = 1'b0;
      @(negedge clk);
      expect_bit("R8 empty", out_valid, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule